// File: doc/BRIEF.md
# Virtual Channel Link Multiplexer

This block drives the transmit side of one unidirectional physical link that is shared by several virtual channels. Each virtual channel has its own flit queue at the sender and its own credit count. The credit count mirrors the free space in that channel's buffer at the far end of the link. Flits of different channels are interleaved on the link at one flit per cycle. Each channel carries at most one wormhole message at a time: a head flit opens the message and a tail flit closes it.

A mode input chooses how link cycles are shared. In slot mode, a rotating slot counter hands each cycle to one fixed channel. If that channel has nothing to send, or has no credit, the cycle goes idle even when other channels are waiting. In demand mode, a round-robin arbiter gives the cycle to the next channel that has both a flit and a credit. The receiver is represented only by one credit-return pulse per channel.

Top module: `vc_link_mux`

## Requirements
- R1: After reset, `link_valid` is 0, every bit of `wr_ready` is 1, and each channel holds `RX_DEPTH` credits. A channel can therefore send `RX_DEPTH` flits back to back before any credit is returned.
- R2: A write with `wr_head`=1 is accepted only when that channel has no open message. A write with `wr_head`=0 is accepted only while a message is open. Any other write is dropped. A flit with head=1 and tail=1 is a whole message in one flit. A tail flit that is accepted closes the message.
- R3: Each channel queue holds `FIFO_DEPTH` flits. `wr_ready[v]` is 0 exactly when queue v is full. A write to a full queue is dropped.
- R4: A channel sends only while its credit count is above zero. Each flit sent uses one credit. Each pulse on `credit_rtn[v]` adds one credit, and that credit can first be used in the cycle after the pulse.
- R5: `sel_demand`=0 selects slot mode. A slot counter starts at 0 after reset and advances by one every cycle, modulo `NUM_VC`. The cycle whose slot is k can send only from channel k, and it sends nothing if channel k has no flit or no credit.
- R6: `sel_demand`=1 selects demand mode. Among the channels that have a flit and a credit, the first one at or after a round-robin pointer is granted. The pointer then moves to the channel after the one granted. The pointer starts at 0 and changes only on grants made in demand mode.
- R7: The flit chosen in a cycle appears on the link outputs one cycle later. It carries the channel number on `link_vc`, the head and tail flags, and the data. Flits of one channel leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_demand | input | 1 | 0 = slot mode, 1 = demand mode |
| wr_valid | input | 1 | Flit write strobe |
| wr_vc | input | VC_W | Channel that the flit is written to |
| wr_head | input | 1 | Flit opens a message |
| wr_tail | input | 1 | Flit closes a message |
| wr_data | input | DATA_W | Flit payload |
| wr_ready | output | NUM_VC | Per-channel queue not full |
| credit_rtn | input | NUM_VC | Per-channel credit return pulse |
| link_valid | output | 1 | A flit is on the link this cycle |
| link_vc | output | VC_W | Channel of the flit on the link |
| link_head | output | 1 | Head flag of the flit on the link |
| link_tail | output | 1 | Tail flag of the flit on the link |
| link_data | output | DATA_W | Payload of the flit on the link |

## Verification
The bench first checks that slot mode leaves a cycle idle when its owner is empty while other channels hold flits. A design that lets another channel use the spare slot would put that channel's flit on the link early. It then checks the demand pointer across credit stalls, where a channel whose credit arrives in the same cycle must not be granted until the next cycle. A design that grants with a stale credit, or that moves the pointer wrongly, changes the order of the flits that come out. Misplaced head and body writes must be dropped, and so must a write to a full queue; a design that accepts either one would put an unexpected flit on the link. Finally, the drain after the queue fills must produce exactly the accepted flits, in order.

// File: rtl/vc_link_mux.sv
module vc_link_mux #(
  parameter int NUM_VC     = 4,
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int RX_DEPTH   = 2,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int PTR_W = $clog2(FIFO_DEPTH),
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int CRD_W = $clog2(RX_DEPTH + 1),
  localparam int ENT_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_demand,
  input  logic              wr_valid,
  input  logic [VC_W-1:0]   wr_vc,
  input  logic              wr_head,
  input  logic              wr_tail,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_VC-1:0] wr_ready,
  input  logic [NUM_VC-1:0] credit_rtn,
  output logic              link_valid,
  output logic [VC_W-1:0]   link_vc,
  output logic              link_head,
  output logic              link_tail,
  output logic [DATA_W-1:0] link_data
);

  function automatic logic [VC_W-1:0] vc_add(input logic [VC_W-1:0] a, input int k);
    int s;
    s = int'(a) + k;
    if (s >= NUM_VC) s = s - NUM_VC;
    return VC_W'(s);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FIFO_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [NUM_VC-1:0] elig;
  logic [ENT_W-1:0]  front [NUM_VC];
  logic [VC_W-1:0]   slot_q, rr_q, dm_vc, gnt_vc;
  logic              dm_hit, send;

  always_comb begin
    dm_hit = 1'b0;
    dm_vc  = '0;
    for (int i = NUM_VC - 1; i >= 0; i--) begin
      if (elig[vc_add(rr_q, i)]) begin
        dm_hit = 1'b1;
        dm_vc  = vc_add(rr_q, i);
      end
    end
  end

  assign send   = sel_demand ? dm_hit : elig[slot_q];
  assign gnt_vc = sel_demand ? dm_vc : slot_q;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic [ENT_W-1:0] mem_q [FIFO_DEPTH];
    logic [PTR_W-1:0] rd_q, wp_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CRD_W-1:0] crd_q;
    logic             open_q, push, pop;

    assign push = wr_valid && (wr_vc == VC_W'(v)) && (wr_head != open_q)
                  && (cnt_q != CNT_W'(FIFO_DEPTH));
    assign pop  = send && (gnt_vc == VC_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q   <= '0;
        wp_q   <= '0;
        cnt_q  <= '0;
        crd_q  <= CRD_W'(RX_DEPTH);
        open_q <= 1'b0;
      end else begin
        if (push) begin
          wp_q   <= ptr_inc(wp_q);
          open_q <= !wr_tail;
        end
        if (pop) rd_q <= ptr_inc(rd_q);
        if (push && !pop)      cnt_q <= cnt_q + 1'b1;
        else if (!push && pop) cnt_q <= cnt_q - 1'b1;
        if (credit_rtn[v] && !pop && crd_q != CRD_W'(RX_DEPTH)) crd_q <= crd_q + 1'b1;
        else if (!credit_rtn[v] && pop)                          crd_q <= crd_q - 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem_q[wp_q] <= {wr_head, wr_tail, wr_data};
    end

    assign front[v]    = mem_q[rd_q];
    assign elig[v]     = (cnt_q != '0) && (crd_q != '0);
    assign wr_ready[v] = cnt_q != CNT_W'(FIFO_DEPTH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= '0;
      rr_q       <= '0;
      link_valid <= 1'b0;
      link_vc    <= '0;
      link_head  <= 1'b0;
      link_tail  <= 1'b0;
      link_data  <= '0;
    end else begin
      slot_q     <= vc_add(slot_q, 1);
      link_valid <= send;
      if (sel_demand && dm_hit) rr_q <= vc_add(dm_vc, 1);
      if (send) begin
        link_vc <= gnt_vc;
        {link_head, link_tail, link_data} <= front[gnt_vc];
      end
    end
  end

endmodule

// File: rtl/vc_link_mux_chk.sv
module vc_link_mux_chk #(
  parameter int NUM_VC   = 4,
  parameter int RX_DEPTH = 2,
  localparam int VC_W = $clog2(NUM_VC),
  localparam int OW   = $clog2(RX_DEPTH + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_demand,
  input logic              wr_valid,
  input logic [VC_W-1:0]   wr_vc,
  input logic [NUM_VC-1:0] wr_ready,
  input logic [NUM_VC-1:0] credit_rtn,
  input logic              link_valid,
  input logic [VC_W-1:0]   link_vc,
  input logic              link_head,
  input logic              link_tail,
  input logic [NUM_VC-1:0] elig
);

  logic [VC_W-1:0] slot_ref;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_ref <= '0;
    else        slot_ref <= (slot_ref == VC_W'(NUM_VC - 1)) ? '0 : slot_ref + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!link_valid && (&wr_ready)));

  assert_slot_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && !$past(sel_demand)) |-> (link_vc == $past(slot_ref)));

  assert_work_conserve_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_demand && (|elig)) |=> link_valid);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    logic [OW-1:0] outst;
    logic          open_l;
    logic          sent;

    assign sent = link_valid && (link_vc == VC_W'(v));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        outst  <= '0;
        open_l <= 1'b0;
      end else begin
        if (sent && !credit_rtn[v])      outst <= outst + 1'b1;
        else if (!sent && credit_rtn[v]) outst <= outst - 1'b1;
        if (sent) open_l <= !link_tail;
      end
    end

    assert_credit_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      outst <= OW'(RX_DEPTH));

    assert_head_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sent |-> (link_head == !open_l));

    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_ready[v]) |-> $past(wr_valid && (wr_vc == VC_W'(v))));
  end

endmodule

bind vc_link_mux vc_link_mux_chk #(.NUM_VC(NUM_VC), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_demand(sel_demand), .wr_valid(wr_valid),
  .wr_vc(wr_vc), .wr_ready(wr_ready), .credit_rtn(credit_rtn),
  .link_valid(link_valid), .link_vc(link_vc), .link_head(link_head),
  .link_tail(link_tail), .elig(elig)
);

// File: tb/vc_link_mux_bench.sv
`timescale 1ns/1ps
module vc_link_mux_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_demand = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_vc = '0;
  logic        wr_head = 1'b0, wr_tail = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0]  wr_ready;
  logic [3:0]  credit_rtn = '0;
  logic        link_valid, link_head, link_tail;
  logic [1:0]  link_vc;
  logic [15:0] link_data;
  int n_chk = 0, n_fail = 0, got = 0;

  always #2 clk = ~clk;

  vc_link_mux #(.NUM_VC(4), .DATA_W(16), .FIFO_DEPTH(4), .RX_DEPTH(2)) u_vc_link_mux (
    .clk(clk), .rst_n(rst_n), .sel_demand(sel_demand), .wr_valid(wr_valid),
    .wr_vc(wr_vc), .wr_head(wr_head), .wr_tail(wr_tail), .wr_data(wr_data),
    .wr_ready(wr_ready), .credit_rtn(credit_rtn), .link_valid(link_valid),
    .link_vc(link_vc), .link_head(link_head), .link_tail(link_tail), .link_data(link_data));

  typedef struct packed {
    logic dm; logic wv; logic [1:0] vc; logic hd; logic tl; logic [15:0] d; logic [3:0] cr;
    logic ev; logic [1:0] evc; logic eh; logic et; logic [15:0] ed;
  } vec_t;

  // rows 1-9 slot mode (R5, R4 credit use), rows 10-16 demand mode (R6, R4 stall, R7 order)
  localparam vec_t TBL [16] = '{
    '{1'b0,1'b1,2'd0,1'b1,1'b0,16'hA000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b1,2'd0,1'b0,1'b1,16'hA001,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b1,2'd2,1'b1,1'b1,16'hC000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b1,2'd0,1'b1,1'b0,16'hA000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b1,2'd2,1'b1,1'b1,16'hC000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b0,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b1,2'd0,1'b0,1'b1,16'hA001},
    '{1'b1,1'b1,2'd0,1'b1,1'b1,16'hB000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b1,1'b1,2'd1,1'b1,1'b0,16'hD000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000},
    '{1'b1,1'b1,2'd3,1'b1,1'b1,16'hE000,4'h0, 1'b1,2'd1,1'b1,1'b0,16'hD000},
    '{1'b1,1'b1,2'd1,1'b0,1'b1,16'hD001,4'h1, 1'b1,2'd3,1'b1,1'b1,16'hE000},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b1,2'd0,1'b1,1'b1,16'hB000},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b1,2'd1,1'b0,1'b1,16'hD001},
    '{1'b1,1'b0,2'd0,1'b0,1'b0,16'h0000,4'h0, 1'b0,2'd0,1'b0,1'b0,16'h0000}
  };

  task automatic cyc(input logic dm, input logic wv, input logic [1:0] vc, input logic hd,
                     input logic tl, input logic [15:0] d, input logic [3:0] cr);
    sel_demand = dm; wr_valid = wv; wr_vc = vc; wr_head = hd; wr_tail = tl;
    wr_data = d; credit_rtn = cr;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic dm);
    cyc(dm, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 4'h0);
  endtask

  task automatic chk_link(input string tag, input logic ev, input logic [1:0] evc,
                          input logic eh, input logic et, input logic [15:0] ed);
    n_chk++;
    if (link_valid !== ev || (ev && (link_vc !== evc || link_head !== eh ||
        link_tail !== et || link_data !== ed))) begin
      n_fail++;
      $display("FAIL %s: got v=%b vc=%0d h=%b t=%b d=%h, want v=%b vc=%0d h=%b t=%b d=%h",
               tag, link_valid, link_vc, link_head, link_tail, link_data, ev, evc, eh, et, ed);
    end
  endtask

  task automatic chk_ready(input string tag, input logic [3:0] exp);
    n_chk++;
    if (wr_ready !== exp) begin
      n_fail++;
      $display("FAIL %s: wr_ready got %b want %b", tag, wr_ready, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_demand = 1'b0; wr_valid = 1'b0; credit_rtn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic grab();
    if (link_valid) begin
      n_chk++;
      if (link_vc !== 2'd1 || link_data !== 16'(16'h3100 + got)) begin
        n_fail++;
        $display("FAIL R3 drain: got vc=%0d d=%h want vc=1 d=%h", link_vc, link_data,
                 16'(16'h3100 + got));
      end
      got++;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang want completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    chk_link("R1 reset link idle", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    chk_ready("R1 reset ready", 4'hF);

    for (int i = 0; i < 16; i++) begin
      cyc(TBL[i].dm, TBL[i].wv, TBL[i].vc, TBL[i].hd, TBL[i].tl, TBL[i].d, TBL[i].cr);
      chk_link(TBL[i].dm ? "R6 table demand" : "R5 table slot", TBL[i].ev, TBL[i].evc,
               TBL[i].eh, TBL[i].et, TBL[i].ed);
    end

    // R2: misplaced body and head writes dropped
    do_reset();
    cyc(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 16'h1111, 4'h0);
    chk_link("R2 body on idle vc", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    cyc(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 16'h2000, 4'h0);
    chk_link("R2 body on idle vc dropped", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    cyc(1'b1, 1'b1, 2'd2, 1'b1, 1'b0, 16'h2BAD, 4'h0);
    chk_link("R2 head sent", 1'b1, 2'd2, 1'b1, 1'b0, 16'h2000);
    cyc(1'b1, 1'b1, 2'd2, 1'b0, 1'b1, 16'h2001, 4'h0);
    chk_link("R2 second head dropped", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    idle(1'b1);
    chk_link("R7 tail follows head", 1'b1, 2'd2, 1'b0, 1'b1, 16'h2001);
    idle(1'b1);
    chk_link("R2 nothing left", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);

    // R4: credits of vc2 exhausted
    cyc(1'b1, 1'b1, 2'd2, 1'b1, 1'b1, 16'h2002, 4'h0);
    chk_link("R4 stall write cycle", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    idle(1'b1);
    chk_link("R4 no credit no send", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    cyc(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 4'b0100);
    chk_link("R4 credit not usable same cycle", 1'b0, 2'd0, 1'b0, 1'b0, 16'h0);
    idle(1'b1);
    chk_link("R4 send after credit", 1'b1, 2'd2, 1'b1, 1'b1, 16'h2002);

    // R1 full credit count, then R3 full queue
    do_reset();
    cyc(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 16'h3000, 4'h0);
    cyc(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 16'h3001, 4'h0);
    chk_link("R1 first credit", 1'b1, 2'd1, 1'b1, 1'b1, 16'h3000);
    idle(1'b1);
    chk_link("R1 second credit", 1'b1, 2'd1, 1'b1, 1'b1, 16'h3001);
    for (int k = 0; k < 5; k++) begin
      cyc(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 16'(16'h3100 + k), 4'h0);
      if (k == 2) chk_ready("R3 three entries", 4'hF);
      if (k == 3) chk_ready("R3 full", 4'b1101);
    end
    chk_ready("R3 still full", 4'b1101);
    got = 0;
    for (int it = 0; it < 4; it++) begin
      cyc(1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0, 4'b0010);
      grab();
      idle(1'b1);
      grab();
      idle(1'b1);
      grab();
    end
    n_chk++;
    if (got != 4) begin
      n_fail++;
      $display("FAIL R3 drain count: got %0d want 4", got);
    end
    chk_ready("R3 empty after drain", 4'hF);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule